// File: doc/BRIEF.md
# Watchdog Timer with Keyed Reconfiguration

This block is a watchdog timer for a bus-attached peripheral slot. It leaves reset already running with a built-in timeout. Software keeps it alive by writing a refresh word. Its three configuration registers (control, timeout, refresh window) are normally locked. To change them, software writes a two-word key to the key register. This opens a fixed-length configuration window. Inside that window each register accepts one write. The staged values take effect together when the window ends, and the count then restarts from zero.

The control register carries an update-permit bit. While the active value of that bit is 1, the key sequence can be used again later. Once a configuration with the bit cleared has been applied, the settings stay frozen until the next reset. A timeout, a refresh that arrives too early in window mode, or a window that closes with no register written all raise an interrupt. A fixed grace period after that, the block raises a reset request.

Top module: `wd_guard`

## Requirements
- R1: After reset the active control is 3'b011 (bit 0 count enable = 1, bit 1 update permit = 1, bit 2 window mode = 0), the active timeout is TOUT_DEF, and the active window is 0. The outputs irq, rst_req, cfg_open and wr_blocked are all low.
- R2: Bus address 3 is the key register. Writing 16'hC520 there, and then 16'hD928 at most KEY_GAP clocks later, unlocks the block. If the second word arrives later than that, the unlock is abandoned.
- R3: If any other word is written to address 3 between the two key words, the unlock is abandoned and no window opens.
- R4: A configuration write on the clock right after the second key word is ignored, and it sets wr_blocked.
- R5: After an unlock, cfg_open is high for exactly CFG_WIN clocks. Writes made in that time to address 0 (control), 1 (timeout) or 2 (window) become active together when cfg_open falls.
- R6: Each configuration register accepts only its first write in a window. Later writes to it in the same window are ignored.
- R7: Configuration writes made while cfg_open is low change no active value, and they set the sticky flag wr_blocked.
- R8: A new unlock is possible only while the active update-permit bit is 1. Once a configuration with that bit at 0 is applied, unlock attempts have no effect until reset.
- R9: If a window closes with no configuration register written, irq rises on the clock when cfg_open falls.
- R10: Key words written while a window is open neither restart nor extend it.
- R11: When the count is enabled and no refresh occurs, irq rises TOUT+1 clocks after the configuration is applied, where TOUT is the active timeout.
- R12: rst_req rises GRACE clocks after irq rises. Both then stay high until reset.
- R13: Writing 16'hB480 to address 3 clears the count. In window mode, a refresh made while the count is still below the active window raises irq.
- R14: With count enable at 0, the count holds and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 timeout, 2 window, 3 key/refresh |
| bus_wdata | input | 16 | Write data |
| irq | output | 1 | Pre-reset interrupt, sticky |
| rst_req | output | 1 | Reset request, sticky |
| cfg_open | output | 1 | Configuration window is open |
| wr_blocked | output | 1 | Sticky flag: a configuration write was refused while locked |
| act_ctrl | output | 3 | Active control bits |
| act_tout | output | 16 | Active timeout |
| act_window | output | 16 | Active refresh window |

## Verification
The bench probes the key gap exactly at its limit and one clock beyond it. A counter that is off by one would accept a late key or refuse a valid one. It writes a configuration register in the dead clock after the key and writes the same register twice in one window. A design without the dead clock, or without write-once tracking, would apply the wrong value. It sends key words into an open window and measures the window's length, which catches a window that restarts. It also measures the exact delays from applying a configuration to irq and from irq to rst_req. Further cases cover a window closed with no writes, an early refresh in window mode, and a frozen configuration that would still unlock if the update-permit bit were ignored.

// File: rtl/wd_pkg.sv
package wd_pkg;
    localparam int BUS_W  = 16;
    localparam int CTRL_W = 3;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_TOUT = 2'd1;
    localparam logic [1:0] ADDR_WIN  = 2'd2;
    localparam logic [1:0] ADDR_KEY  = 2'd3;

    localparam logic [BUS_W-1:0] KEY_FIRST  = 16'hC520;
    localparam logic [BUS_W-1:0] KEY_SECOND = 16'hD928;
    localparam logic [BUS_W-1:0] KEY_FEED   = 16'hB480;

    localparam int BIT_EN    = 0;
    localparam int BIT_ALLOW = 1;
    localparam int BIT_WMODE = 2;

    typedef enum logic [1:0] {
        UL_IDLE,
        UL_KEY1,
        UL_DEAD,
        UL_OPEN
    } ul_state_e;
endpackage

// File: rtl/wd_unlock.sv
module wd_unlock
    import wd_pkg::*;
#(
    parameter int KEY_GAP = 20,
    parameter int CFG_WIN = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_we,
    input  logic [BUS_W-1:0] wdata,
    input  logic             allow,
    output logic             win_open,
    output logic             win_close
);
    localparam int GAP_W = $clog2(KEY_GAP + 1);
    localparam int WIN_W = $clog2(CFG_WIN + 1);

    typedef struct packed {
        ul_state_e        st;
        logic [GAP_W-1:0] gap;
        logic [WIN_W-1:0] wcnt;
    } ul_s;

    ul_s q, d;

    always_comb begin
        d = q;
        case (q.st)
            UL_IDLE: begin
                if (key_we && wdata == KEY_FIRST && allow) begin
                    d.st  = UL_KEY1;
                    d.gap = GAP_W'(1);
                end
            end
            UL_KEY1: begin
                if (key_we) begin
                    d.st = (wdata == KEY_SECOND) ? UL_DEAD : UL_IDLE;
                end else if (q.gap >= GAP_W'(KEY_GAP)) begin
                    d.st = UL_IDLE;
                end else begin
                    d.gap = q.gap + GAP_W'(1);
                end
            end
            UL_DEAD: begin
                d.st   = UL_OPEN;
                d.wcnt = '0;
            end
            default: begin
                if (q.wcnt == WIN_W'(CFG_WIN - 1)) d.st = UL_IDLE;
                else d.wcnt = q.wcnt + WIN_W'(1);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: UL_IDLE, gap: '0, wcnt: '0};
        else        q <= d;
    end

    assign win_open  = (q.st == UL_OPEN);
    assign win_close = (q.st == UL_OPEN) && (q.wcnt == WIN_W'(CFG_WIN - 1));

    // R2: a pending first key never outlives the gap limit
    a_r2_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == UL_KEY1 |-> q.gap <= GAP_W'(KEY_GAP));
    // R4: the dead clock is always followed by the open window
    a_r4_dead_then_open: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == UL_DEAD |=> q.st == UL_OPEN);
    // R8: frozen settings never start a key sequence
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == UL_IDLE && !allow) |=> q.st != UL_KEY1);
    // R10: an open window only advances until it closes
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == UL_OPEN && !win_close) |=> (q.st == UL_OPEN && q.wcnt != '0));
endmodule

// File: rtl/wd_cfg.sv
module wd_cfg
    import wd_pkg::*;
#(
    parameter logic [BUS_W-1:0] TOUT_DEF = 16'd8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              win_open,
    input  logic              win_close,
    output logic [CTRL_W-1:0] act_ctrl,
    output logic [BUS_W-1:0]  act_tout,
    output logic [BUS_W-1:0]  act_win,
    output logic              blocked,
    output logic              restart,
    output logic              empty_fault
);
    typedef struct packed {
        logic [CTRL_W-1:0] stg_ctrl;
        logic [BUS_W-1:0]  stg_tout;
        logic [BUS_W-1:0]  stg_win;
        logic [2:0]        done;
        logic [CTRL_W-1:0] act_ctrl;
        logic [BUS_W-1:0]  act_tout;
        logic [BUS_W-1:0]  act_win;
        logic              blocked;
    } cfg_s;

    cfg_s q, d;
    logic any_wr;

    always_comb begin
        d = q;
        if (we && addr != ADDR_KEY) begin
            if (!win_open) begin
                d.blocked = 1'b1;
            end else begin
                case (addr)
                    ADDR_CTRL: if (!q.done[0]) begin
                        d.done[0]  = 1'b1;
                        d.stg_ctrl = wdata[CTRL_W-1:0];
                    end
                    ADDR_TOUT: if (!q.done[1]) begin
                        d.done[1]  = 1'b1;
                        d.stg_tout = wdata;
                    end
                    default: if (!q.done[2]) begin
                        d.done[2] = 1'b1;
                        d.stg_win = wdata;
                    end
                endcase
            end
        end
        any_wr = |d.done;
        if (win_close) begin
            if (d.done[0]) d.act_ctrl = d.stg_ctrl;
            if (d.done[1]) d.act_tout = d.stg_tout;
            if (d.done[2]) d.act_win  = d.stg_win;
            d.done = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.act_ctrl <= CTRL_W'(3'b011);
            q.act_tout <= TOUT_DEF;
        end else begin
            q <= d;
        end
    end

    assign act_ctrl    = q.act_ctrl;
    assign act_tout    = q.act_tout;
    assign act_win     = q.act_win;
    assign blocked     = q.blocked;
    assign restart     = win_close && any_wr;
    assign empty_fault = win_close && !any_wr;

    // R7: active settings change only on a window close
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !win_close |=> $stable({q.act_ctrl, q.act_tout, q.act_win}));
    // R7: refused-write flag is sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.blocked |=> q.blocked);
    // R6: a second timeout write in one window leaves the staged value alone
    a_r6_once: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && we && addr == ADDR_TOUT && q.done[1]) |=> $stable(q.stg_tout));
endmodule

// File: rtl/wd_timer.sv
module wd_timer
    import wd_pkg::*;
#(
    parameter int GRACE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wmode,
    input  logic [BUS_W-1:0] tout,
    input  logic [BUS_W-1:0] win,
    input  logic             feed,
    input  logic             restart,
    input  logic             ext_fault,
    output logic             irq,
    output logic             rst_req
);
    localparam int GR_W = $clog2(GRACE + 1);

    typedef struct packed {
        logic [BUS_W-1:0] cnt;
        logic             fault;
        logic [GR_W-1:0]  gcnt;
        logic             rreq;
    } tm_s;

    tm_s q, d;
    logic early_feed, expired;

    always_comb begin
        d          = q;
        early_feed = feed && wmode && (q.cnt < win);
        expired    = en && (q.cnt >= tout);
        if (!q.fault) begin
            if (restart || feed) d.cnt = '0;
            else if (en)         d.cnt = q.cnt + BUS_W'(1);
            if (expired || early_feed || ext_fault) d.fault = 1'b1;
        end else if (!q.rreq) begin
            if (q.gcnt == GR_W'(GRACE - 1)) d.rreq = 1'b1;
            d.gcnt = q.gcnt + GR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq     = q.fault;
    assign rst_req = q.rreq;

    // R12: the reset request never appears without the interrupt
    a_r12_order: assert property (@(posedge clk) disable iff (!rst_n)
        q.rreq |-> q.fault);
    // R12: the interrupt is sticky
    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.fault |=> q.fault);
    // R14: a disabled, unfed counter holds its value
    a_r14_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !restart && !feed && !q.fault) |=> $stable(q.cnt));
endmodule

// File: rtl/wd_guard.sv
module wd_guard
    import wd_pkg::*;
#(
    parameter int               KEY_GAP  = 20,
    parameter int               CFG_WIN  = 128,
    parameter int               GRACE    = 16,
    parameter logic [15:0]      TOUT_DEF = 16'd8000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic        irq,
    output logic        rst_req,
    output logic        cfg_open,
    output logic        wr_blocked,
    output logic [2:0]  act_ctrl,
    output logic [15:0] act_tout,
    output logic [15:0] act_window
);
    logic key_we, feed, win_close, restart, empty_fault;

    assign key_we = bus_we && (bus_addr == ADDR_KEY);
    assign feed   = key_we && (bus_wdata == KEY_FEED);

    wd_unlock #(.KEY_GAP(KEY_GAP), .CFG_WIN(CFG_WIN)) u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_we   (key_we),
        .wdata    (bus_wdata),
        .allow    (act_ctrl[BIT_ALLOW]),
        .win_open (cfg_open),
        .win_close(win_close)
    );

    wd_cfg #(.TOUT_DEF(TOUT_DEF)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (bus_we),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .win_open   (cfg_open),
        .win_close  (win_close),
        .act_ctrl   (act_ctrl),
        .act_tout   (act_tout),
        .act_win    (act_window),
        .blocked    (wr_blocked),
        .restart    (restart),
        .empty_fault(empty_fault)
    );

    wd_timer #(.GRACE(GRACE)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (act_ctrl[BIT_EN]),
        .wmode    (act_ctrl[BIT_WMODE]),
        .tout     (act_tout),
        .win      (act_window),
        .feed     (feed),
        .restart  (restart),
        .ext_fault(empty_fault),
        .irq      (irq),
        .rst_req  (rst_req)
    );
endmodule

// File: tb/tb_wd_guard.sv
module tb_wd_guard;
    localparam int KEY_GAP  = 20;
    localparam int CFG_WIN  = 128;
    localparam int GRACE    = 16;
    localparam int TOUT_DEF = 8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic        irq, rst_req, cfg_open, wr_blocked;
    logic [2:0]  act_ctrl;
    logic [15:0] act_tout, act_window;

    int total = 0;
    int bad = 0;
    int open_cycles = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    wd_guard #(.KEY_GAP(KEY_GAP), .CFG_WIN(CFG_WIN), .GRACE(GRACE),
               .TOUT_DEF(16'(TOUT_DEF))) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .irq(irq), .rst_req(rst_req),
        .cfg_open(cfg_open), .wr_blocked(wr_blocked), .act_ctrl(act_ctrl),
        .act_tout(act_tout), .act_window(act_window)
    );

    always @(negedge clk) if (cfg_open) open_cycles++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: all requirements, actual=%0d cycles expected<=150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        bus_we = 1'b0;
        rst_n  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic unlock();
        wr(2'd3, 16'hC520);
        wr(2'd3, 16'hD928);
        @(negedge clk);
    endtask

    task automatic wait_close();
        while (cfg_open) @(negedge clk);
    endtask

    task automatic configure(input logic [2:0] c, input logic [15:0] t, input logic [15:0] w);
        unlock();
        wr(2'd0, {13'd0, c});
        wr(2'd1, t);
        wr(2'd2, w);
        wait_close();
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 ctrl", int'(act_ctrl), 3);
        chk("R1 tout", int'(act_tout), TOUT_DEF);
        chk("R1 window", int'(act_window), 0);
        chk("R1 outputs", int'({irq, rst_req, cfg_open, wr_blocked}), 0);
    endtask

    task automatic t_locked_write();
        do_reset();
        wr(2'd1, 16'd55);
        chk("R7 tout unchanged", int'(act_tout), TOUT_DEF);
        chk("R7 blocked flag", int'(wr_blocked), 1);
        repeat (5) @(negedge clk);
        chk("R7 flag sticky", int'(wr_blocked), 1);
    endtask

    task automatic t_gap_limit_and_timing();
        int n;
        do_reset();
        wr(2'd3, 16'hC520);
        repeat (KEY_GAP - 1) @(negedge clk);
        wr(2'd3, 16'hD928);
        @(negedge clk);
        chk("R2 open at gap limit", int'(cfg_open), 1);
        wr(2'd0, 16'd3);
        wr(2'd1, 16'd40);
        wait_close();
        chk("R5 tout applied", int'(act_tout), 40);
        n = 0;
        while (!irq && n < 1000) begin @(negedge clk); n++; end
        chk("R11 irq delay", n, 41);
        chk("R12 no early rst", int'(rst_req), 0);
        n = 0;
        while (!rst_req && n < 1000) begin @(negedge clk); n++; end
        chk("R12 rst delay", n, GRACE);
        repeat (5) @(negedge clk);
        chk("R12 sticky", int'({irq, rst_req}), 3);
    endtask

    task automatic t_gap_late();
        do_reset();
        wr(2'd3, 16'hC520);
        repeat (KEY_GAP) @(negedge clk);
        wr(2'd3, 16'hD928);
        repeat (3) @(negedge clk);
        chk("R2 late key rejected", int'(cfg_open), 0);
    endtask

    task automatic t_wrong_key();
        do_reset();
        wr(2'd3, 16'hC520);
        wr(2'd3, 16'h1234);
        wr(2'd3, 16'hD928);
        repeat (3) @(negedge clk);
        chk("R3 wrong key no window", int'(cfg_open), 0);
        wr(2'd1, 16'd99);
        chk("R3 still locked", int'(act_tout), TOUT_DEF);
    endtask

    task automatic t_dead_cycle();
        do_reset();
        wr(2'd3, 16'hC520);
        wr(2'd3, 16'hD928);
        wr(2'd1, 16'd77);
        chk("R4 dead write flagged", int'(wr_blocked), 1);
        wr(2'd2, 16'd5);
        wait_close();
        chk("R4 dead write ignored", int'(act_tout), TOUT_DEF);
        chk("R5 window applied", int'(act_window), 5);
    endtask

    task automatic t_window_len();
        do_reset();
        open_cycles = 0;
        unlock();
        wr(2'd3, 16'hC520);
        wr(2'd3, 16'hD928);
        wr(2'd1, 16'd3000);
        wait_close();
        chk("R10 R5 window length", open_cycles, CFG_WIN);
        chk("R5 tout applied", int'(act_tout), 3000);
    endtask

    task automatic t_write_once();
        do_reset();
        unlock();
        wr(2'd1, 16'd100);
        wr(2'd1, 16'd200);
        wait_close();
        chk("R6 first write kept", int'(act_tout), 100);
    endtask

    task automatic t_empty_window();
        do_reset();
        unlock();
        wait_close();
        chk("R9 empty window irq", int'(irq), 1);
    endtask

    task automatic t_freeze();
        do_reset();
        configure(3'b001, 16'd3000, 16'd0);
        chk("R8 ctrl applied", int'(act_ctrl), 1);
        wr(2'd3, 16'hC520);
        wr(2'd3, 16'hD928);
        repeat (3) @(negedge clk);
        chk("R8 frozen no window", int'(cfg_open), 0);
        do_reset();
        configure(3'b011, 16'd2000, 16'd0);
        configure(3'b011, 16'd2500, 16'd0);
        chk("R8 reconfig allowed", int'(act_tout), 2500);
    endtask

    task automatic t_refresh();
        do_reset();
        configure(3'b011, 16'd60, 16'd0);
        for (int i = 0; i < 5; i++) begin
            repeat (40) @(negedge clk);
            wr(2'd3, 16'hB480);
        end
        chk("R13 refresh keeps alive", int'(irq), 0);
        repeat (80) @(negedge clk);
        chk("R11 timeout without refresh", int'(irq), 1);
    endtask

    task automatic t_window_refresh();
        do_reset();
        configure(3'b111, 16'd200, 16'd50);
        wr(2'd3, 16'hB480);
        chk("R13 early refresh faults", int'(irq), 1);
        do_reset();
        configure(3'b111, 16'd200, 16'd50);
        for (int i = 0; i < 3; i++) begin
            repeat (60) @(negedge clk);
            wr(2'd3, 16'hB480);
        end
        chk("R13 late refresh ok", int'(irq), 0);
    endtask

    task automatic t_disable();
        do_reset();
        configure(3'b010, 16'd20, 16'd0);
        repeat (100) @(negedge clk);
        chk("R14 disabled no timeout", int'(irq), 0);
    endtask

    initial begin
        t_reset_state();
        t_locked_write();
        t_gap_limit_and_timing();
        t_gap_late();
        t_wrong_key();
        t_dead_cycle();
        t_window_len();
        t_write_once();
        t_empty_window();
        t_freeze();
        t_refresh();
        t_window_refresh();
        t_disable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule